// File: doc/BRIEF.md
# Multi-lane readout data merger

This block gathers one event from sixteen front-end digitizer channels that arrive at the same time, each on its own two-bit serial lane. Every lane is framed on its own by a start strobe and may lag or stall relative to the others. Each lane rebuilds 32-bit words from its bit pairs, checks a CRC-16 over its segment and keeps the words in a small per-lane FIFO.

A merger then drains the FIFOs in ascending channel order and emits every word of the event on a single 32-bit valid/ready stream. It closes the event with a CRC-32 trailer word computed over everything it sent. Each channel has an error flag that reports whether its most recent segment failed the CRC-16 check.

Top module: `lane_merge_top`

## Requirements
- R1: A lane turns bit pairs into a word MSB-first. The first pair of a word becomes bits 31:30 and the sixteenth pair becomes bits 1:0. A word is complete after 16 pairs taken while `lane_vld_i` is high. Cycles with `lane_vld_i` low are gaps and add nothing.
- R2: Lanes are framed and shifted independently. Any skew or gap pattern on one lane leaves the words of the other lanes unchanged.
- R3: A segment is `SEG_WORDS` words long, 4 by default. A pair taken with `lane_sof_i` high starts a new segment at bit 31 of word 0, and any partial word or partial segment already under way on that lane is discarded.
- R4: The CRC-16 is polynomial 0x8005 with initial value 0x0000. It is computed MSB-first over the first `SEG_WORDS-1` words of a segment and compared with bits 15:0 of the last word. `chan_err_o[c]` shows the result (1 means mismatch) from the cycle after the last pair is taken, and is cleared by the next start strobe on that lane.
- R5: The output carries all `SEG_WORDS` words of channel 0, including the check word, then all words of channel 1, and so on up to channel 15.
- R6: After the last word of channel 15 comes one trailer word. It is the CRC-32 (polynomial 0x04C11DB7, initial value 0xFFFFFFFF, MSB-first, no final inversion) of all data words of the event in output order. `out_eoe_o` is high on the trailer and on no other word.
- R7: While `out_vld_o` is high and `out_rdy_i` is low, `out_vld_o`, `out_data_o` and `out_eoe_o` stay unchanged.
- R8: `out_vld_o` is low whenever the next word in order has not yet been received.
- R9: After reset `out_vld_o` is low and every `chan_err_o` bit is 0.
- R10: Pairs taken while a lane is idle, after a finished segment and without a start strobe, are ignored.
- R11: Each lane buffers up to `FIFO_DEPTH` (16) complete words. A lane can therefore finish its whole segment while the merger is still busy with lower channels or the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_pair_i | input | 2*N_LANES | Bit pair of each lane; lane c uses bits 2c+1:2c |
| lane_vld_i | input | N_LANES | Pair valid, one bit per lane |
| lane_sof_i | input | N_LANES | Segment start strobe, taken together with a valid pair |
| out_data_o | output | 32 | Output word |
| out_vld_o | output | 1 | Output word valid |
| out_rdy_i | input | 1 | Downstream ready |
| out_eoe_o | output | 1 | Marks the CRC-32 trailer word |
| chan_err_o | output | N_LANES | CRC-16 mismatch flag of each channel's last segment |

## Verification
The assertions assume that no lane starts a new segment before the merger has drained that lane's previous one. Under that assumption a lane FIFO never receives a word while full and is never popped while empty. The bench meets this by sending one event at a time and waiting for the trailer before starting the next. Skew, gaps, junk pairs and restarts are placed per lane so that each lane's total stays at one segment, and the downstream stall patterns only slow the drain.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int WORD_W = 32;
  localparam logic [31:0] CRC32_INIT = 32'hFFFF_FFFF;

  function automatic logic [15:0] crc16_word(logic [15:0] c, logic [31:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h8005;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] crc32_word(logic [31:0] c, logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ 32'h04C1_1DB7;
      else              r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/lm_lane_rx.sv
module lm_lane_rx #(
  parameter int SEG_WORDS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  pair_i,
  input  logic        vld_i,
  input  logic        sof_i,
  output logic        push_o,
  output logic [31:0] word_o,
  output logic        last_o,
  output logic        err_o
);
  import lm_pkg::*;
  localparam int WCW = (SEG_WORDS > 1) ? $clog2(SEG_WORDS) : 1;

  logic [31:0]    sh_q, base, word_nx;
  logic [3:0]     pcnt_q, cnt_base;
  logic [WCW-1:0] wcnt_q;
  logic [15:0]    crc_q;
  logic           act_q, take, done;

  always_comb begin
    base     = sof_i ? '0 : sh_q;
    cnt_base = sof_i ? '0 : pcnt_q;
    word_nx  = {base[29:0], pair_i};
    take     = vld_i && (sof_i || act_q);   // R10: idle pairs dropped
    done     = take && (cnt_base == 4'd15);
  end

  assign push_o = done;
  assign word_o = word_nx;
  assign last_o = (wcnt_q == WCW'(SEG_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      pcnt_q <= '0;
      wcnt_q <= '0;
      crc_q  <= '0;
      act_q  <= 1'b0;
      err_o  <= 1'b0;
    end else if (take) begin
      sh_q   <= word_nx;
      pcnt_q <= cnt_base + 4'd1;
      if (sof_i) begin
        act_q  <= 1'b1;
        wcnt_q <= '0;
        crc_q  <= '0;
        err_o  <= 1'b0;
      end
      if (done) begin
        if (last_o) begin
          act_q  <= 1'b0;
          wcnt_q <= '0;
          err_o  <= (word_nx[15:0] != crc_q);
        end else begin
          crc_q  <= crc16_word(crc_q, word_nx);
          wcnt_q <= wcnt_q + WCW'(1);
        end
      end
    end
  end

  // R4
  err_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(push_o && last_o));
endmodule

// File: rtl/lm_fifo.sv
module lm_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, rptr_q;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);
  assign rdata_o = mem[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 1'b1;
      if (pop_i)  rptr_q <= rptr_q + 1'b1;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/lm_merge.sv
module lm_merge #(
  parameter int N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      empty_i,
  input  logic [N-1:0][32:0] rdata_i,
  output logic [N-1:0]      pop_o,
  output logic [31:0]       data_o,
  output logic              vld_o,
  output logic              eoe_o,
  input  logic              rdy_i
);
  import lm_pkg::*;
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] ch_q;
  logic          tr_q, vld_q, eoe_q, load, avail;
  logic [31:0]   crc_q, data_q;
  logic [32:0]   cur;

  always_comb begin
    load  = !vld_q || rdy_i;
    avail = tr_q || !empty_i[ch_q];
    cur   = rdata_i[ch_q];
    pop_o = (load && avail && !tr_q) ? (N'(1) << ch_q) : '0;
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
  assign eoe_o  = vld_q && eoe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q   <= '0;
      tr_q   <= 1'b0;
      vld_q  <= 1'b0;
      eoe_q  <= 1'b0;
      data_q <= '0;
      crc_q  <= CRC32_INIT;
    end else if (load) begin
      vld_q <= avail;
      if (avail) begin
        if (tr_q) begin
          data_q <= crc_q;
          eoe_q  <= 1'b1;
          crc_q  <= CRC32_INIT;
          tr_q   <= 1'b0;
          ch_q   <= '0;
        end else begin
          data_q <= cur[31:0];
          eoe_q  <= 1'b0;
          crc_q  <= crc32_word(crc_q, cur[31:0]);
          if (cur[32]) begin
            if (ch_q == CW'(N - 1)) tr_q <= 1'b1;
            else                    ch_q <= ch_q + CW'(1);
          end
        end
      end
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !rdy_i) |=> (vld_o && $stable(data_o) && $stable(eoe_o)));
  // R5
  pop_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o));
  // R6
  single_eoe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && rdy_i && eoe_o) |=> !eoe_o);
endmodule

// File: rtl/lane_merge_top.sv
module lane_merge_top #(
  parameter int N_LANES    = 16,
  parameter int SEG_WORDS  = 4,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*N_LANES-1:0] lane_pair_i,
  input  logic [N_LANES-1:0]   lane_vld_i,
  input  logic [N_LANES-1:0]   lane_sof_i,
  output logic [31:0]          out_data_o,
  output logic                 out_vld_o,
  input  logic                 out_rdy_i,
  output logic                 out_eoe_o,
  output logic [N_LANES-1:0]   chan_err_o
);
  localparam int FW = 33;

  logic [N_LANES-1:0]         push, last, pop, empty, full;
  logic [N_LANES-1:0][31:0]   word;
  logic [N_LANES-1:0][FW-1:0] fifo_rd;

  for (genvar c = 0; c < N_LANES; c++) begin : g_lane
    lm_lane_rx #(.SEG_WORDS(SEG_WORDS)) u_rx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pair_i (lane_pair_i[2*c +: 2]),
      .vld_i  (lane_vld_i[c]),
      .sof_i  (lane_sof_i[c]),
      .push_o (push[c]),
      .word_o (word[c]),
      .last_o (last[c]),
      .err_o  (chan_err_o[c])
    );

    lm_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[c]),
      .wdata_i ({last[c], word[c]}),
      .pop_i   (pop[c]),
      .rdata_o (fifo_rd[c]),
      .empty_o (empty[c]),
      .full_o  (full[c])
    );
  end

  lm_merge #(.N(N_LANES)) u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .empty_i (empty),
    .rdata_i (fifo_rd),
    .pop_o   (pop),
    .data_o  (out_data_o),
    .vld_o   (out_vld_o),
    .eoe_o   (out_eoe_o),
    .rdy_i   (out_rdy_i)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (!out_vld_o && (chan_err_o == '0)));
endmodule

// File: tb/sim_lane_merge_top.sv
module sim_lane_merge_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL  = 16;
  localparam int SEG = 4;
  localparam int EVW = NL * SEG;
  localparam int ML  = 200;

  logic            clk = 0, rst_n = 0;
  logic [2*NL-1:0] lane_pair = '0;
  logic [NL-1:0]   lane_vld = '0, lane_sof = '0, chan_err;
  logic [31:0]     out_data;
  logic            out_vld, out_rdy = 0, out_eoe;

  int checks = 0, fails = 0, cyc = 0;
  logic [3:0]  ent [NL][ML];
  int          len [NL];
  logic [31:0] rx_data [128];
  logic        rx_eoe [128];
  int          n_rx, hold_bad;

  lane_merge_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .lane_pair_i(lane_pair), .lane_vld_i(lane_vld),
    .lane_sof_i(lane_sof), .out_data_o(out_data), .out_vld_o(out_vld),
    .out_rdy_i(out_rdy), .out_eoe_o(out_eoe), .chan_err_o(chan_err));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] c16(logic [15:0] c, logic [31:0] d);
    for (int i = 31; i >= 0; i--) c = (c[15] ^ d[i]) ? ((c << 1) ^ 16'h8005) : (c << 1);
    return c;
  endfunction

  function automatic logic [31:0] c32(logic [31:0] c, logic [31:0] d);
    for (int i = 31; i >= 0; i--) c = (c[31] ^ d[i]) ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    return c;
  endfunction

  function automatic logic [31:0] exp_word(int e, int l, int w, bit bad);
    logic [15:0] c;
    if (w < SEG - 1) return (32'h9E3779B9 * (e * 64 + l * 4 + w + 1)) ^ 32'h5A5A_0F0F;
    c = 16'h0000;
    for (int k = 0; k < SEG - 1; k++) c = c16(c, exp_word(e, l, k, 0));
    return {16'(e * 256 + l), c ^ (bad ? 16'h0001 : 16'h0000)};
  endfunction

  task automatic add(int l, bit v, bit s, logic [1:0] p);
    ent[l][len[l]] = {v, s, p};
    len[l]++;
  endtask

  // skew / gap / junk / restart shaping of one lane
  task automatic build(int e, int l, int skew, bit gaps, bit junk, bit restart, bit bad);
    logic [31:0] w;
    len[l] = 0;
    for (int i = 0; i < skew; i++) add(l, 0, 0, 2'b00);
    if (junk)    for (int i = 0; i < 6; i++) add(l, 1, 0, 2'(i));
    if (restart) for (int i = 0; i < 5; i++) add(l, 1, (i == 0), 2'b11);
    for (int p = 0; p < SEG * 16; p++) begin
      w = exp_word(e, l, p / 16, bad);
      add(l, 1, (p == 0), w[31 - 2*(p % 16) -: 2]);
      if (gaps && (p % (l % 3 + 2)) == 1) add(l, 0, 0, 2'b01);
    end
  endtask

  task automatic drive();
    int mx = 0;
    for (int l = 0; l < NL; l++) if (len[l] > mx) mx = len[l];
    for (int t = 0; t < mx; t++) begin
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
        if (t < len[l]) begin
          lane_vld[l] = ent[l][t][3];
          lane_sof[l] = ent[l][t][2];
          lane_pair[2*l +: 2] = ent[l][t][1:0];
        end else begin
          lane_vld[l] = 0; lane_sof[l] = 0;
        end
      end
    end
    @(negedge clk);
    lane_vld = '0; lane_sof = '0;
  endtask

  task automatic collect(int mode);
    logic pv = 0, pr = 0, r;
    logic [31:0] pd = '0;
    bit got_eoe = 0;
    n_rx = 0; hold_bad = 0;
    for (int t = 0; t < 4000 && !got_eoe; t++) begin
      @(negedge clk);
      if (pv && !pr && !(out_vld && out_data == pd)) hold_bad++;
      case (mode)
        0: r = 1;
        1: r = (t % 3) != 0;
        default: r = (t % 9) < 2;
      endcase
      out_rdy = r;
      if (out_vld && r) begin
        if (n_rx < 128) begin rx_data[n_rx] = out_data; rx_eoe[n_rx] = out_eoe; end
        n_rx++;
        if (out_eoe) got_eoe = 1;
      end
      pv = out_vld; pr = r; pd = out_data;
    end
    @(negedge clk);
    out_rdy = 0;
  endtask

  task automatic run_event(int e, bit skew, bit gaps, int mode, logic [NL-1:0] bad,
                           int junk_lane, int rst_lane, string tag);
    logic [31:0] crc = 32'hFFFFFFFF;
    int bad_idx = -1, eoe_bad = 0;
    for (int l = 0; l < NL; l++)
      build(e, l, skew ? ((l * 7) % 31) : 0, gaps, (l == junk_lane), (l == rst_lane), bad[l]);
    fork
      drive();
      collect(mode);
    join
    chk(n_rx == EVW + 1, {tag, " R5 word count"}, n_rx, EVW + 1);
    for (int i = 0; i < EVW && i < n_rx; i++) begin
      if (bad_idx < 0 && rx_data[i] != exp_word(e, i / SEG, i % SEG, bad[i / SEG])) bad_idx = i;
      if (rx_eoe[i]) eoe_bad++;
      crc = c32(crc, exp_word(e, i / SEG, i % SEG, bad[i / SEG]));
    end
    chk(bad_idx < 0, {tag, " R1 R5 data order"}, bad_idx < 0 ? 0 : rx_data[bad_idx],
        bad_idx < 0 ? 0 : exp_word(e, bad_idx / SEG, bad_idx % SEG, bad[bad_idx / SEG]));
    chk(eoe_bad == 0 && n_rx == EVW + 1 && rx_eoe[EVW], {tag, " R6 eoe only on trailer"}, eoe_bad, 0);
    chk(n_rx == EVW + 1 && rx_data[EVW] == crc, {tag, " R6 trailer crc32"}, rx_data[EVW], crc);
    chk(chan_err == bad, {tag, " R4 channel error flags"}, chan_err, bad);
    chk(hold_bad == 0, {tag, " R7 hold while stalled"}, hold_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_vld == 0, "R9 valid low after reset", out_vld, 0);
    chk(chan_err == '0, "R9 error flags clear after reset", chan_err, 0);
  endtask

  task automatic t_idle();
    int seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_vld) seen++;
    end
    chk(seen == 0, "R8 valid low with no pending data", seen, 0);
  endtask

  // R10: idle lanes get valid pairs without a start strobe; nothing may come out
  task automatic t_idle_junk();
    int seen = 0;
    out_rdy = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      lane_vld = '1; lane_sof = '0; lane_pair = 32'hA5C3_3C5A ^ 32'(i);
      if (out_vld) seen++;
    end
    @(negedge clk);
    lane_vld = '0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (out_vld) seen++;
    end
    out_rdy = 0;
    chk(seen == 0, "R10 pairs without start ignored", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_idle();
    run_event(1, 0, 0, 0, 16'h0000, -1, -1, "E1 aligned");
    run_event(2, 1, 1, 1, 16'h0000, -1, -1, "E2 R2 skew+gaps");
    run_event(3, 1, 0, 2, 16'h0104, -1, -1, "E3 R11 crc errors stalled");
    t_idle_junk();
    run_event(4, 1, 1, 0, 16'h0000, 5, 3, "E4 R3 R10 restart+junk");
    t_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule